// File: doc/BRIEF.md
# Event-Triggered Gate Generator Bank

This block is the gating core of an accelerator timing client. It runs on the clock recovered from the serial event link, so one clock tick is the timing resolution of every channel. It takes decoded event codes and a once-per-machine-cycle data frame from upstream logic. The frame carries the cycle number, a special-cycle flag and one gate width per channel. Link decoding and fine analog delay belong to other blocks.

Each of the eight channels waits for its programmed event code. A channel can also be set to fire on the machine cycle-start event. When the trigger is accepted, the channel counts a programmed number of ticks, raises its gate for the width taken from the latest frame, and then drops it. A per-channel 64-bit repetition mask, indexed by the cycle number, decides whether a trigger is accepted on the current cycle. On special cycles, channels that opt in fire whatever their mask says. A divided clock output is re-phased on every cycle-start event.

Top module: `evg_gate_bank`

## Requirements
- R1: During reset and right after it, every gate output and the clock output are low.
- R2: A channel is triggered when its event code (channel i at `cfg_codes[i*8 +: 8]`) arrives with `ev_valid` high. If the delay D (`cfg_delays[i*16 +: 16]`) is nonzero, the gate goes high D ticks after the clock edge that samples the event, and stays high for exactly W ticks.
- R3: A channel with `cfg_use_cs[i]` set is also triggered by the cycle-start code (default 8'h01), with the same delay and width timing.
- R4: A frame (`frm_valid` high) replaces the stored cycle number, special flag and widths (channel i at `frm_widths[i*16 +: 16]`). A channel takes its width when it is triggered, so a frame that arrives during the delay does not change the pulse in progress.
- R5: A trigger is accepted only when bit (cycle number mod 64) of the channel's mask (`cfg_patterns[i*64 +: 64]`) is 1. Otherwise no gate follows.
- R6: When the stored special flag is 1 and `cfg_spec_en[i]` is 1, the channel fires regardless of its mask. The flag has no effect on a channel whose bit is 0.
- R7: A trigger that arrives while a channel is in its delay or gate phase is ignored. The pulse in progress keeps its timing and its width.
- R8: A stored width of zero suppresses the gate entirely.
- R9: With delay zero, the gate is high in the tick right after the edge that samples the event.
- R10: `clk_o` has a period of CLK_DIV ticks (default 4) and is high for the first half of each period. A cycle-start event restarts the period, so `clk_o` is high for the first CLK_DIV/2 ticks after that event is sampled.
- R11: Channels are independent. A trigger for one channel leaves every other gate low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered event-link clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event code valid this tick |
| ev_code | input | 8 | Decoded event code |
| frm_valid | input | 1 | Per-cycle data frame valid |
| frm_cycle | input | 16 | Machine cycle number |
| frm_special | input | 1 | Special-cycle flag |
| frm_widths | input | 128 | Gate width per channel, in ticks |
| cfg_codes | input | 64 | Trigger event code per channel |
| cfg_delays | input | 128 | Delay per channel, in ticks |
| cfg_patterns | input | 512 | Repetition mask per channel |
| cfg_use_cs | input | 8 | Also trigger on cycle-start, per channel |
| cfg_spec_en | input | 8 | Special cycles force firing, per channel |
| gate_o | output | 8 | Gate outputs |
| clk_o | output | 1 | Divided clock, phased to cycle start |

## Verification
Each channel's internal state shows directly at its gate pin, so a faulty counter shows up within one pulse: the rising edge lands on the wrong tick, or the high time is too long or too short. A state machine that does not return to idle shows up on the next trigger, which then produces no pulse. A wrong mask index or a badly latched frame shows up as a pulse that appears or goes missing on the very next trigger after that frame. A clock divider that is not re-phased shows up within two ticks of a cycle-start event.

// File: rtl/evg_pkg.sv
`timescale 1ns/1ps
package evg_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_DELAY = 2'd1,
    CH_GATE  = 2'd2
  } ch_state_e;

  // Index into a repetition mask of length len for a given cycle number.
  function automatic int unsigned mask_index(input int unsigned cycle, input int unsigned len);
    return cycle % len;
  endfunction

  // High phase of the divided clock: first half of the period.
  function automatic logic div_high(input int unsigned phase, input int unsigned period);
    return phase < (period / 2);
  endfunction

endpackage

// File: rtl/evg_frame_regs.sv
`timescale 1ns/1ps
module evg_frame_regs #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned CNTW = 16,
  parameter int unsigned CYCW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frm_valid,
  input  logic [CYCW-1:0]     frm_cycle,
  input  logic                frm_special,
  input  logic [NCH*CNTW-1:0] frm_widths,
  output logic [CYCW-1:0]     cur_cycle,
  output logic                cur_special,
  output logic [NCH*CNTW-1:0] cur_widths
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_cycle   <= '0;
      cur_special <= 1'b0;
      cur_widths  <= '0;
    end else if (frm_valid) begin
      cur_cycle   <= frm_cycle;
      cur_special <= frm_special;
      cur_widths  <= frm_widths;
    end
  end

endmodule

// File: rtl/evg_channel.sv
`timescale 1ns/1ps
module evg_channel
  import evg_pkg::*;
#(
  parameter int unsigned     EVW     = 8,
  parameter int unsigned     CNTW    = 16,
  parameter int unsigned     PATW    = 64,
  parameter int unsigned     CYCW    = 16,
  parameter logic [EVW-1:0]  CS_CODE = 'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [EVW-1:0]   ev_code,
  input  logic [EVW-1:0]   cfg_code,
  input  logic             cfg_use_cs,
  input  logic             cfg_spec_en,
  input  logic [CNTW-1:0]  cfg_delay,
  input  logic [PATW-1:0]  cfg_pattern,
  input  logic [CNTW-1:0]  cur_width,
  input  logic [CYCW-1:0]  cur_cycle,
  input  logic             cur_special,
  output logic             gate,
  output logic             busy,
  output logic             fire
);

  localparam int unsigned IDXW = (PATW > 1) ? $clog2(PATW) : 1;

  ch_state_e       state;
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] w_lat;
  logic            hit;
  logic            rep_ok;
  logic [IDXW-1:0] idx;

  assign idx    = IDXW'(mask_index(32'(cur_cycle), PATW));
  assign hit    = ev_valid && ((ev_code == cfg_code) ||
                               (cfg_use_cs && (ev_code == CS_CODE)));
  assign rep_ok = cfg_pattern[idx] || (cur_special && cfg_spec_en);
  assign fire   = (state == CH_IDLE) && hit && rep_ok && (cur_width != '0);
  assign busy   = (state != CH_IDLE);
  assign gate   = (state == CH_GATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CH_IDLE;
      cnt   <= '0;
      w_lat <= '0;
    end else begin
      unique case (state)
        CH_IDLE: begin
          if (fire) begin
            w_lat <= cur_width;
            if (cfg_delay == '0) begin
              state <= CH_GATE;
              cnt   <= cur_width - CNTW'(1);
            end else begin
              state <= CH_DELAY;
              cnt   <= cfg_delay - CNTW'(1);
            end
          end
        end
        CH_DELAY: begin
          if (cnt == '0) begin
            state <= CH_GATE;
            cnt   <= w_lat - CNTW'(1);
          end else begin
            cnt <= cnt - CNTW'(1);
          end
        end
        CH_GATE: begin
          if (cnt == '0) state <= CH_IDLE;
          else           cnt   <= cnt - CNTW'(1);
        end
        default: state <= CH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/evg_clkdiv.sv
`timescale 1ns/1ps
module evg_clkdiv
  import evg_pkg::*;
#(
  parameter int unsigned    DIV     = 4,
  parameter int unsigned    EVW     = 8,
  parameter logic [EVW-1:0] CS_CODE = 'h01
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_valid,
  input  logic [EVW-1:0] ev_code,
  output logic           clk_o
);

  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] phase;
  logic [CW-1:0] phase_nxt;
  logic          cs_seen;

  assign cs_seen = ev_valid && (ev_code == CS_CODE);

  always_comb begin
    if (cs_seen || (phase == CW'(DIV - 1))) phase_nxt = '0;
    else                                    phase_nxt = phase + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      clk_o <= 1'b0;
    end else begin
      phase <= phase_nxt;
      clk_o <= div_high(32'(phase_nxt), DIV);
    end
  end

endmodule

// File: rtl/evg_gate_bank.sv
`timescale 1ns/1ps
module evg_gate_bank #(
  parameter int unsigned    NCH     = 8,
  parameter int unsigned    EVW     = 8,
  parameter int unsigned    CNTW    = 16,
  parameter int unsigned    PATW    = 64,
  parameter int unsigned    CYCW    = 16,
  parameter int unsigned    CLK_DIV = 4,
  parameter logic [EVW-1:0] CS_CODE = 'h01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  input  logic [EVW-1:0]      ev_code,
  input  logic                frm_valid,
  input  logic [CYCW-1:0]     frm_cycle,
  input  logic                frm_special,
  input  logic [NCH*CNTW-1:0] frm_widths,
  input  logic [NCH*EVW-1:0]  cfg_codes,
  input  logic [NCH*CNTW-1:0] cfg_delays,
  input  logic [NCH*PATW-1:0] cfg_patterns,
  input  logic [NCH-1:0]      cfg_use_cs,
  input  logic [NCH-1:0]      cfg_spec_en,
  output logic [NCH-1:0]      gate_o,
  output logic                clk_o
);

  logic [CYCW-1:0]     cur_cycle;
  logic                cur_special;
  logic [NCH*CNTW-1:0] cur_widths;
  logic [NCH-1:0]      ch_fire;
  logic [NCH-1:0]      ch_busy;

  evg_frame_regs #(.NCH(NCH), .CNTW(CNTW), .CYCW(CYCW)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_cycle(frm_cycle),
    .frm_special(frm_special), .frm_widths(frm_widths),
    .cur_cycle(cur_cycle), .cur_special(cur_special), .cur_widths(cur_widths)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    evg_channel #(
      .EVW(EVW), .CNTW(CNTW), .PATW(PATW), .CYCW(CYCW), .CS_CODE(CS_CODE)
    ) u_ch (
      .clk(clk), .rst_n(rst_n),
      .ev_valid(ev_valid), .ev_code(ev_code),
      .cfg_code(cfg_codes[i*EVW +: EVW]),
      .cfg_use_cs(cfg_use_cs[i]),
      .cfg_spec_en(cfg_spec_en[i]),
      .cfg_delay(cfg_delays[i*CNTW +: CNTW]),
      .cfg_pattern(cfg_patterns[i*PATW +: PATW]),
      .cur_width(cur_widths[i*CNTW +: CNTW]),
      .cur_cycle(cur_cycle),
      .cur_special(cur_special),
      .gate(gate_o[i]), .busy(ch_busy[i]), .fire(ch_fire[i])
    );
  end

  evg_clkdiv #(.DIV(CLK_DIV), .EVW(EVW), .CS_CODE(CS_CODE)) u_clk (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_code(ev_code),
    .clk_o(clk_o)
  );

endmodule

// File: rtl/evg_checker.sv
`timescale 1ns/1ps
module evg_checker #(
  parameter int unsigned    NCH     = 8,
  parameter int unsigned    EVW     = 8,
  parameter int unsigned    CYCW    = 16,
  parameter logic [EVW-1:0] CS_CODE = 'h01
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_valid,
  input logic [EVW-1:0]  ev_code,
  input logic            frm_valid,
  input logic [CYCW-1:0] frm_cycle,
  input logic [CYCW-1:0] cur_cycle,
  input logic [NCH-1:0]  ch_fire,
  input logic [NCH-1:0]  ch_busy,
  input logic [NCH-1:0]  gate_o,
  input logic            clk_o
);

  // R4: a frame's cycle number is held from the next tick on
  a_r4_cycle_latched: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> (cur_cycle == $past(frm_cycle)));

  // R10: the divided clock is high right after a cycle-start event
  a_r10_clk_high_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code == CS_CODE) |=> clk_o);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R7: an accepted trigger makes the channel busy, so further triggers are ignored
    a_r7_busy_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
      ch_fire[i] |=> ch_busy[i]);

    // R2: a gate only rises after an accepted trigger or out of the delay phase
    a_r2_gate_from_fire: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_o[i]) |-> $past(ch_fire[i] || ch_busy[i]));

    // R2: the channel is idle once its gate has dropped
    a_r2_idle_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_o[i]) |-> !ch_busy[i]);
  end

endmodule

bind evg_gate_bank evg_checker #(
  .NCH(NCH), .EVW(EVW), .CYCW(CYCW), .CS_CODE(CS_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ev_valid(ev_valid), .ev_code(ev_code),
  .frm_valid(frm_valid), .frm_cycle(frm_cycle),
  .cur_cycle(cur_cycle),
  .ch_fire(ch_fire), .ch_busy(ch_busy),
  .gate_o(gate_o), .clk_o(clk_o)
);

// File: tb/evg_gate_bank_tb.sv
`timescale 1ns/1ps
module evg_gate_bank_tb;

  localparam int NCH = 8, EVW = 8, CNTW = 16, PATW = 64, CYCW = 16, DIV = 4;
  localparam logic [EVW-1:0] CS = 8'h01;
  localparam logic [PATW-1:0] PAT0 = 64'h8000_0000_0000_0005;
  localparam int MAXW = 40;

  typedef struct packed {
    logic [15:0] dly;
    logic [15:0] wid;
    logic [15:0] cyc;
    logic        spc;
    logic        sen;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'd3, 16'd4, 16'd0,   1'b0, 1'b0},
    '{16'd0, 16'd1, 16'd2,   1'b0, 1'b0},
    '{16'd5, 16'd2, 16'd1,   1'b0, 1'b0},
    '{16'd2, 16'd3, 16'd127, 1'b0, 1'b0},
    '{16'd1, 16'd2, 16'd65,  1'b1, 1'b1},
    '{16'd1, 16'd2, 16'd65,  1'b1, 1'b0},
    '{16'd4, 16'd0, 16'd0,   1'b0, 1'b0}
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                ev_valid = 1'b0;
  logic [EVW-1:0]      ev_code = '0;
  logic                frm_valid = 1'b0;
  logic [CYCW-1:0]     frm_cycle = '0;
  logic                frm_special = 1'b0;
  logic [NCH*CNTW-1:0] frm_widths = '0;
  logic [NCH*EVW-1:0]  cfg_codes;
  logic [NCH*CNTW-1:0] cfg_delays;
  logic [NCH*PATW-1:0] cfg_patterns;
  logic [NCH-1:0]      cfg_use_cs;
  logic [NCH-1:0]      cfg_spec_en;
  logic [NCH-1:0]      gate_o;
  logic                clk_o;

  int checks = 0;
  int errors = 0;
  int first_hi [NCH];
  int n_hi [NCH];
  logic clk_hist [MAXW];

  always #4 clk = ~clk;

  evg_gate_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_code(ev_code),
    .frm_valid(frm_valid), .frm_cycle(frm_cycle),
    .frm_special(frm_special), .frm_widths(frm_widths),
    .cfg_codes(cfg_codes), .cfg_delays(cfg_delays),
    .cfg_patterns(cfg_patterns), .cfg_use_cs(cfg_use_cs),
    .cfg_spec_en(cfg_spec_en),
    .gate_o(gate_o), .clk_o(clk_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input int cyc, input bit spc, input int w0, input int wrest);
    @(negedge clk);
    frm_valid = 1'b1;
    frm_cycle = CYCW'(cyc);
    frm_special = spc;
    for (int c = 0; c < NCH; c++)
      frm_widths[c*CNTW +: CNTW] = CNTW'((c == 0) ? w0 : wrest);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  // Sends one event, then watches win ticks. At tick inj_at, kind 1 repeats the
  // event and kind 2 sends a frame setting every width to 9.
  task automatic shot(input logic [EVW-1:0] code, input int win, input int inj_at, input int kind);
    for (int c = 0; c < NCH; c++) begin first_hi[c] = -1; n_hi[c] = 0; end
    @(negedge clk);
    ev_valid = 1'b1; ev_code = code;
    @(negedge clk);
    ev_valid = 1'b0;
    for (int t = 0; t < win; t++) begin
      for (int c = 0; c < NCH; c++) if (gate_o[c]) begin
        if (first_hi[c] < 0) first_hi[c] = t;
        n_hi[c]++;
      end
      if (t < MAXW) clk_hist[t] = clk_o;
      if (t == inj_at && kind == 1) begin ev_valid = 1'b1; ev_code = code; end
      if (t == inj_at && kind == 2) begin
        frm_valid = 1'b1; frm_cycle = '0; frm_special = 1'b0;
        for (int c = 0; c < NCH; c++) frm_widths[c*CNTW +: CNTW] = CNTW'(9);
      end
      @(negedge clk);
      ev_valid = 1'b0; frm_valid = 1'b0;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      cfg_codes[c*EVW +: EVW] = EVW'(8'h10 + c);
      cfg_delays[c*CNTW +: CNTW] = CNTW'(1 + c);
      cfg_patterns[c*PATW +: PATW] = (c == 0) ? PAT0 : '1;
    end
    cfg_use_cs = 8'b0000_0010;
    cfg_spec_en = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(gate_o == '0, "R1 gates in reset", int'(gate_o), 0);
    chk(clk_o == 1'b0, "R1 clk_o in reset", int'(clk_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gate_o == '0, "R1 gates after reset", int'(gate_o), 0);

    // Table: R2, R5, R6, R8, R9, R11 on channel 0
    for (int v = 0; v < NV; v++) begin
      bit exp_fire;
      int d, w;
      d = int'(VECS[v].dly);
      w = int'(VECS[v].wid);
      cfg_delays[0 +: CNTW] = VECS[v].dly;
      cfg_spec_en[0] = VECS[v].sen;
      send_frame(int'(VECS[v].cyc), VECS[v].spc, w, 3);
      exp_fire = (w != 0) &&
                 (PAT0[int'(VECS[v].cyc) % 64] || (VECS[v].spc && VECS[v].sen));
      shot(8'h10, d + w + 4, -1, 0);
      chk(first_hi[0] == (exp_fire ? d : -1), "R2/R5/R6/R9 rise tick", first_hi[0], exp_fire ? d : -1);
      chk(n_hi[0] == (exp_fire ? w : 0), "R2/R6/R8 high ticks", n_hi[0], exp_fire ? w : 0);
      for (int c = 1; c < NCH; c++)
        chk(n_hi[c] == 0, "R11 other channel quiet", n_hi[c], 0);
    end
    cfg_spec_en = '0;

    // R7: repeat event during the delay is ignored
    cfg_delays[0 +: CNTW] = 16'd3;
    send_frame(0, 1'b0, 4, 3);
    shot(8'h10, 14, 1, 1);
    chk(first_hi[0] == 3, "R7 rise with repeat during delay", first_hi[0], 3);
    chk(n_hi[0] == 4, "R7 width with repeat during delay", n_hi[0], 4);
    // R7: repeat event during the gate is ignored
    shot(8'h10, 14, 4, 1);
    chk(n_hi[0] == 4, "R7 width with repeat during gate", n_hi[0], 4);

    // R4: a frame during the delay does not change the running pulse
    shot(8'h10, 14, 1, 2);
    chk(n_hi[0] == 4, "R4 width captured at trigger", n_hi[0], 4);
    shot(8'h10, 18, -1, 0);
    chk(n_hi[0] == 9, "R4 refreshed width used next", n_hi[0], 9);

    // R3 and R10: cycle-start event triggers channel 1 and re-phases clk_o
    send_frame(0, 1'b0, 4, 3);
    repeat (3) @(negedge clk);
    shot(CS, 12, -1, 0);
    chk(first_hi[1] == 2 && n_hi[1] == 3, "R3 cycle-start trigger rise", first_hi[1], 2);
    chk(n_hi[1] == 3, "R3 cycle-start trigger width", n_hi[1], 3);
    chk(n_hi[0] == 0, "R3 channel without cycle-start mode", n_hi[0], 0);
    for (int t = 0; t < 8; t++)
      chk(clk_hist[t] == ((t % DIV) < DIV / 2), "R10 clk_o phase", int'(clk_hist[t]), int'((t % DIV) < DIV / 2));

    // R11: channel 5 fires alone with its own delay
    shot(8'h15, 12, -1, 0);
    chk(first_hi[5] == 6 && n_hi[5] == 3, "R11 channel 5 pulse", first_hi[5], 6);
    for (int c = 0; c < NCH; c++)
      if (c != 5) chk(n_hi[c] == 0, "R11 other channels", n_hi[c], 0);

    // R3: cycle-start channel still answers its own code
    shot(8'h11, 10, -1, 0);
    chk(first_hi[1] == 2 && n_hi[1] == 3, "R3 own code on channel 1", n_hi[1], 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule